// File: doc/BRIEF.md
# Bidirectional Parallel Port with Direction Register

This block is a small peripheral port that gives a CPU control over one group of eight bidirectional pins through two bus addresses. The address with its low bit set reaches a control byte. The address with its low bit clear is a shared window. Bit 2 of the control byte picks what the window reaches: the direction register when the bit is 0, or the output data latch when the bit is 1.

Each pin drives the value in its output latch bit when its direction bit is 1. When its direction bit is 0 the pin is an input and is sampled through a two-stage synchroniser. Software normally clears control bit 2 once at start-up, writes the direction mask through the window, and then sets bit 2 so that later traffic through the window reaches the data path.

The window choice is held as a two-state machine. `WIN_DIR` routes window accesses to the direction register. `WIN_DATA` routes them to the data path. A control write with bit 2 set moves the machine to `WIN_DATA`. A control write with bit 2 clear moves it to `WIN_DIR`. Every other cycle leaves the state where it is. Reset enters `WIN_DIR`. The other seven control bits are stored and read back, and they have no other effect.

Top module: `pport_dir`

## Requirements
- R1: After reset the control byte, the direction register and the output latch are all 0, so `pin_oe` and `pin_out` are 0 and the window selects the direction register.
- R2: A write with `addr`=1 stores all 8 bits of `wdata` as the control byte, and a read with `addr`=1 returns that byte unchanged.
- R3: While control bit 2 is 0, a write with `addr`=0 loads the direction register and leaves the output latch unchanged. A read with `addr`=0 then returns the direction register.
- R4: While control bit 2 is 1, a write with `addr`=0 loads the output latch and leaves the direction register unchanged.
- R5: `pin_oe` always equals the direction register, where a 1 makes that pin an output. `pin_out` always equals the output latch.
- R6: While control bit 2 is 1, a read with `addr`=0 returns, for each bit, the latch bit if the direction bit is 1 and the synchronised pin level if it is 0.
- R7: A change on `pin_in` first shows in a data read after the second rising clock edge that follows it, and not after the first.
- R8: With `cs`=0, `wr` and `rd` have no effect: the registers are unchanged and `rdata` is 0.
- R9: `rdata` is 0 whenever `cs` and `rd` are not both 1.
- R10: A control write changes neither the direction register nor the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select |
| addr | input | 1 | 1 selects the control byte, 0 selects the window |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when no read is in progress |
| pin_out | output | 8 | Values driven onto the pins |
| pin_oe | output | 8 | Per-pin output enable |
| pin_in | input | 8 | Pin levels seen from outside |

## Verification
If the window state is wrong, a write through the window lands in the wrong register. This shows at once on `pin_oe` or `pin_out` in the cycle after the write, and a read of the window returns the wrong register. A corrupted direction bit both flips that pin's enable and changes which source feeds that bit of a data read. If the synchroniser is too short or too long, a pin change appears one cycle early or one cycle late, which a read held open across the two edges that follow the change detects. A control bit that is stored wrongly shows on the next control read.

// File: rtl/pport_pkg.sv
package pport_pkg;
    typedef enum logic {
        WIN_DIR  = 1'b0,
        WIN_DATA = 1'b1
    } win_e;

    localparam int unsigned SEL_BIT = 2;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctrl,
    input  logic         wr_win,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctrl_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] lat_q,
    output win_e         win_q
);
    win_e         win_d;
    logic [W-1:0] ctrl_rest;
    logic         ld_dir, ld_lat;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= WIN_DIR;
        else        win_q <= win_d;
    end

    // next state
    always_comb begin
        win_d = win_q;
        unique case (win_q)
            WIN_DIR:  if (wr_ctrl &&  wdata[SEL_BIT]) win_d = WIN_DATA;
            WIN_DATA: if (wr_ctrl && !wdata[SEL_BIT]) win_d = WIN_DIR;
            default:  win_d = WIN_DIR;
        endcase
    end

    // outputs of the machine: where a window write lands
    always_comb begin
        ld_dir = 1'b0;
        ld_lat = 1'b0;
        unique case (win_q)
            WIN_DIR:  ld_dir = wr_win;
            WIN_DATA: ld_lat = wr_win;
            default:  ld_dir = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_rest <= '0;
            dir_q     <= '0;
            lat_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_rest          <= wdata;
                ctrl_rest[SEL_BIT] <= 1'b0;
            end
            if (ld_dir) dir_q <= wdata;
            if (ld_lat) lat_q <= wdata;
        end
    end

    always_comb begin
        ctrl_q          = ctrl_rest;
        ctrl_q[SEL_BIT] = (win_q == WIN_DATA);
    end
endmodule

// File: rtl/pport_rdmux.sv
module pport_rdmux
    import pport_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         rd_en,
    input  logic         addr,
    input  win_e         win,
    input  logic [W-1:0] ctrl,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] lat,
    input  logic [W-1:0] pin_s,
    output logic [W-1:0] rdata
);
    logic [W-1:0] data_view;

    for (genvar b = 0; b < W; b++) begin : g_view
        assign data_view[b] = dir[b] ? lat[b] : pin_s[b];
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr)                 rdata = ctrl;
            else if (win == WIN_DATA) rdata = data_view;
            else                      rdata = dir;
        end
    end
endmodule

// File: rtl/pport_dir.sv
module pport_dir
    import pport_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs,
    input  logic         addr,
    input  logic         rd,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    input  logic [W-1:0] pin_in
);
    logic         wr_ctrl, wr_win, rd_en;
    logic [W-1:0] ctrl_q, dir_q, lat_q, pin_s;
    win_e         win_q;
    logic         win_is_data;

    assign wr_ctrl     = cs & wr & addr;
    assign wr_win      = cs & wr & ~addr;
    assign rd_en       = cs & rd;
    assign win_is_data = (win_q == WIN_DATA);

    pport_sync #(.W(W), .STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
    );

    pport_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_win(wr_win),
        .wdata(wdata), .ctrl_q(ctrl_q), .dir_q(dir_q), .lat_q(lat_q),
        .win_q(win_q)
    );

    pport_rdmux #(.W(W)) u_rdmux (
        .rd_en(rd_en), .addr(addr), .win(win_q), .ctrl(ctrl_q),
        .dir(dir_q), .lat(lat_q), .pin_s(pin_s), .rdata(rdata)
    );

    assign pin_out = lat_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/pport_dir_chk.sv
module pport_dir_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs,
    input logic         addr,
    input logic         rd,
    input logic         wr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] rdata,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic         win_is_data
);
    // R3
    a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !addr && !win_is_data) |=> (pin_oe == $past(wdata)) && $stable(pin_out));

    // R4
    a_r4_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !addr && win_is_data) |=> (pin_out == $past(wdata)) && $stable(pin_oe));

    // R8
    a_r8_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(pin_out) && $stable(pin_oe));

    // R10
    a_r10_ctrl_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr) |=> $stable(pin_out) && $stable(pin_oe));

    // R2
    a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr) |=> (!(cs && rd && addr && !wr) || rdata == $past(wdata)));

    // R9
    a_r9_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |-> (rdata == '0));
endmodule

bind pport_dir pport_dir_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .win_is_data(win_is_data)
);

// File: tb/pport_dir_bench.sv
`timescale 1ns/1ps
module pport_dir_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, addr = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0, pin_in = '0;
    logic [7:0] rdata, pin_out, pin_oe;

    int checks = 0, fails = 0;
    logic [7:0] m_ctrl = '0, m_dir = '0, m_lat = '0;

    always #2.5 clk = ~clk;

    pport_dir u_pport_dir (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_in(pin_in)
    );

    function automatic logic [7:0] exp_view(logic [7:0] d, logic [7:0] l, logic [7:0] p);
        return (l & d) | (p & ~d);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic bus_write(logic a, logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
        if (a) m_ctrl = d;
        else if (m_ctrl[2]) m_lat = d;
        else m_dir = d;
    endtask

    task automatic bus_read(logic a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1907));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", pin_oe, 8'h00);
        check("R1 out", pin_out, 8'h00);
        bus_read(1'b1, v); check("R1 ctrl", v, 8'h00);
        // R9 idle bus
        #1 check("R9 idle rdata", rdata, 8'h00);

        // R3 direction setup through window
        bus_write(1'b0, 8'hA5);
        check("R3 oe", pin_oe, 8'hA5);
        check("R3 latch untouched", pin_out, 8'h00);
        bus_read(1'b0, v); check("R3 dir readback", v, 8'hA5);

        // R2 control byte, bit2 clear, other bits kept
        bus_write(1'b1, 8'hFB);
        bus_read(1'b1, v); check("R2 ctrl", v, 8'hFB);
        // R10 control write kept registers
        check("R10 oe", pin_oe, 8'hA5);

        // R4 latch through window
        bus_write(1'b1, 8'h04);
        check("R10 oe after sel", pin_oe, 8'hA5);
        bus_write(1'b0, 8'h3C);
        check("R4 out", pin_out, 8'h3C);
        check("R4 dir untouched", pin_oe, 8'hA5);
        check("R5 oe", pin_oe, m_dir);

        // R6 mixed read
        pin_in = 8'h96;
        repeat (3) @(negedge clk);
        bus_read(1'b0, v); check("R6 mixed", v, exp_view(m_dir, m_lat, pin_in));

        // R7 synchroniser latency, all inputs
        bus_write(1'b1, 8'h00);
        bus_write(1'b0, 8'h00);
        bus_write(1'b1, 8'h04);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = 1'b0; pin_in = 8'h69;
        #1 check("R7 before edges", rdata, 8'h96);
        @(posedge clk); #1 check("R7 after one edge", rdata, 8'h96);
        @(posedge clk); #1 check("R7 after two edges", rdata, 8'h69);
        @(negedge clk); cs = 1'b0; rd = 1'b0;

        // R8 strobes without chip select
        @(negedge clk);
        wr = 1'b1; rd = 1'b1; addr = 1'b0; wdata = 8'hFF;
        #1 check("R8 rdata", rdata, 8'h00);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        check("R8 out", pin_out, m_lat);
        check("R8 oe", pin_oe, m_dir);
        bus_read(1'b1, v); check("R8 ctrl", v, m_ctrl);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: bus_write(1'b1, 8'($urandom));
                1: bus_write(1'b0, 8'($urandom));
                2: begin bus_read(1'b1, v); check("R2 rand ctrl", v, m_ctrl); end
                3: begin
                    bus_read(1'b0, v);
                    if (m_ctrl[2]) check("R6 rand view", v, exp_view(m_dir, m_lat, pin_in));
                    else           check("R3 rand dir", v, m_dir);
                end
                default: begin
                    @(negedge clk);
                    pin_in = 8'($urandom);
                    repeat (3) @(negedge clk);
                end
            endcase
            check("R5 rand out", pin_out, m_lat);
        end
        finish_run();
    end
endmodule